// File: doc/BRIEF.md
# Multiplexed Diagnostic Parallel Output

This block drives a narrow parallel debug port from one of two internal sources so that an external converter or logic analyser can show either the baseband signal or the channel impulse response. In baseband mode it sends signed I and Q samples one after the other, each word held for one period of a derived output clock. In impulse-response mode it sends a short burst of unsigned magnitudes read from a small buffer, once per frame, after the processing that fills the buffer reports that it has finished.

Both output clock rates come from the system clock through a shared divider whose terminal count depends on the mode. Data words always change on the same system clock edge that raises the output clock, so a receiver captures them on the falling edge. A side flag carries the I/Q lane in baseband mode and a frame trigger in impulse-response mode. A disable input turns the whole port off and asks the pad ring to release the lines.

Top module: `diag_port_out`

## Requirements
- R1: While `port_dis` is 1, `od_en`, `od_clk`, `od_data` and `od_flag` are all 0, and a fall of `cir_busy` seen in that time starts no burst.
- R2: In baseband mode (`mode_bb` = 1) the words alternate I then Q; the I word is `bb_i` and the Q word is the `bb_q` sampled on the same edge, both passed unchanged as signed values; `bb_take` pulses for one cycle together with each I word.
- R3: In baseband mode `od_flag` is 1 while an I word is shown and 0 while a Q word is shown.
- R4: In baseband mode `od_clk` runs freely with a period of `BB_DIV` system cycles and stays high for `BB_DIV/2` of them.
- R5: In impulse-response mode (`mode_bb` = 0) a 1-to-0 change on `cir_busy` starts a burst at the next divider wrap; its words are `cir_rd_data` read at `cir_addr` = 0, 1, … `CIR_LEN-1`, in that order.
- R6: In impulse-response mode `od_clk` pulses only during a burst, exactly `CIR_LEN` times, with a period of `CIR_DIV` cycles and a high time of `CIR_DIV/2`.
- R7: While the port stays enabled, `od_data` changes only in the system cycle in which `od_clk` rises.
- R8: A fall of `cir_busy` that arrives while a burst is waiting or running is dropped: no second burst follows.
- R9: In impulse-response mode `od_flag` toggles one cycle after each `frame_mark` pulse, so each edge marks one start.
- R10: During reset `od_clk`, `od_data`, `od_flag` and `bb_take` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| port_dis | input | 1 | 1 turns the debug port off |
| mode_bb | input | 1 | 1 selects baseband, 0 impulse response |
| bb_i | input | DATA_W | Current in-phase sample (signed) |
| bb_q | input | DATA_W | Current quadrature sample (signed) |
| bb_take | output | 1 | One-cycle pulse: the I/Q pair has been taken |
| cir_busy | input | 1 | 1 while the impulse response is being computed |
| cir_addr | output | ADDR_W | Read address into the magnitude buffer |
| cir_rd_data | input | DATA_W | Magnitude at `cir_addr`, combinational read |
| frame_mark | input | 1 | One-cycle pulse at each trigger point of the frame |
| od_en | output | 1 | Pad drive enable for the port lines |
| od_clk | output | 1 | Port clock |
| od_data | output | DATA_W | Port data word |
| od_flag | output | 1 | Lane flag or frame trigger |

## Verification
The bench keeps the baseband divider at 6 but builds the block with `CIR_DIV` = 8 and `CIR_LEN` = 4, so a whole impulse-response burst lasts a few dozen cycles. That puts several complete bursts, a request dropped in the middle of one, the clock gating at burst end and a mode change behind a disabled port within a short run, while the baseband lane order and period are seen at their real divider value.

// File: rtl/diag_port_pkg.sv
package diag_port_pkg;
  typedef enum logic {PM_CIR = 1'b0, PM_BB = 1'b1} port_mode_e;
  typedef enum logic {LANE_Q = 1'b0, LANE_I = 1'b1} lane_e;
endpackage

// File: rtl/diag_rate_div.sv
module diag_rate_div
  import diag_port_pkg::*;
#(
  parameter int BB_DIV  = 6,
  parameter int CIR_DIV = 384
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       run,
  input  port_mode_e mode,
  output logic       tick,
  output logic       oclk
);
  localparam int MAX_DIV = (BB_DIV > CIR_DIV) ? BB_DIV : CIR_DIV;
  localparam int CNT_W   = $clog2(MAX_DIV);
  localparam logic [CNT_W-1:0] BB_LAST  = CNT_W'(BB_DIV - 1);
  localparam logic [CNT_W-1:0] CIR_LAST = CNT_W'(CIR_DIV - 1);
  localparam logic [CNT_W-1:0] BB_HALF  = CNT_W'(BB_DIV / 2);
  localparam logic [CNT_W-1:0] CIR_HALF = CNT_W'(CIR_DIV / 2);

  logic [CNT_W-1:0] cnt, cnt_nx, last, half;
  logic             oclk_nx;

  assign last = (mode == PM_BB) ? BB_LAST : CIR_LAST;
  assign half = (mode == PM_BB) ? BB_HALF : CIR_HALF;
  assign tick = run && (cnt == '0);

  always_comb begin
    cnt_nx  = cnt;
    oclk_nx = oclk;
    if (!run) begin
      cnt_nx  = '0;
      oclk_nx = 1'b0;
    end else begin
      cnt_nx = (cnt >= last) ? '0 : cnt + 1'b1;
      if (tick)             oclk_nx = 1'b1;
      else if (cnt >= half) oclk_nx = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt  <= '0;
      oclk <= 1'b0;
    end else begin
      cnt  <= cnt_nx;
      oclk <= oclk_nx;
    end
  end

  AST_CLK_HIGH_TWO: assert property (@(posedge clk) disable iff (!rst_n)
    (run && $rose(oclk)) |=> (oclk || !run)); // R4
  AST_LOW_BEFORE_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && $past(run)) |-> !oclk); // R6
endmodule

// File: rtl/diag_bb_seq.sv
module diag_bb_seq
  import diag_port_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              enable,
  input  logic              tick,
  input  logic [DATA_W-1:0] bb_i,
  input  logic [DATA_W-1:0] bb_q,
  output logic [DATA_W-1:0] word,
  output lane_e             lane,
  output logic              take
);
  logic              want_q, want_q_nx, take_nx;
  logic [DATA_W-1:0] q_hold, q_hold_nx, word_nx;
  lane_e             lane_nx;

  always_comb begin
    want_q_nx = want_q;
    q_hold_nx = q_hold;
    word_nx   = word;
    lane_nx   = lane;
    take_nx   = 1'b0;
    if (!enable) begin
      want_q_nx = 1'b0;
      word_nx   = '0;
      lane_nx   = LANE_Q;
    end else if (tick) begin
      if (!want_q) begin
        word_nx   = bb_i;
        q_hold_nx = bb_q;
        lane_nx   = LANE_I;
        want_q_nx = 1'b1;
        take_nx   = 1'b1;
      end else begin
        word_nx   = q_hold;
        lane_nx   = LANE_Q;
        want_q_nx = 1'b0;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      want_q <= 1'b0;
      q_hold <= '0;
      word   <= '0;
      lane   <= LANE_Q;
      take   <= 1'b0;
    end else begin
      want_q <= want_q_nx;
      q_hold <= q_hold_nx;
      word   <= word_nx;
      lane   <= lane_nx;
      take   <= take_nx;
    end
  end

  AST_TAKE_WITH_I: assert property (@(posedge clk) disable iff (!rst_n)
    take |-> (lane == LANE_I)); // R3
endmodule

// File: rtl/diag_cir_burst.sv
module diag_cir_burst #(
  parameter int DATA_W  = 8,
  parameter int CIR_LEN = 16,
  parameter int ADDR_W  = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              enable,
  input  logic              tick,
  input  logic              busy,
  input  logic [DATA_W-1:0] rd_data,
  output logic [ADDR_W-1:0] addr,
  output logic [DATA_W-1:0] word,
  output logic              word_v
);
  localparam int IDX_W = $clog2(CIR_LEN + 1);
  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(CIR_LEN);

  logic              busy_q, pend, pend_nx, word_v_nx, fall;
  logic [IDX_W-1:0]  nxt, nxt_nx;
  logic [DATA_W-1:0] word_nx;

  assign fall = busy_q && !busy;
  assign addr = nxt[ADDR_W-1:0];

  always_comb begin
    pend_nx   = pend;
    word_v_nx = word_v;
    nxt_nx    = nxt;
    word_nx   = word;
    if (!enable) begin
      pend_nx   = 1'b0;
      word_v_nx = 1'b0;
      nxt_nx    = '0;
      word_nx   = '0;
    end else begin
      if (tick) begin
        if (pend) begin
          word_nx   = rd_data;
          nxt_nx    = IDX_W'(1);
          word_v_nx = 1'b1;
          pend_nx   = 1'b0;
        end else if (word_v) begin
          if (nxt == LAST_IDX) begin
            word_v_nx = 1'b0;
            nxt_nx    = '0;
          end else begin
            word_nx = rd_data;
            nxt_nx  = nxt + 1'b1;
          end
        end
      end
      if (fall && !pend && !word_v) pend_nx = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      pend   <= 1'b0;
      word_v <= 1'b0;
      nxt    <= '0;
      word   <= '0;
    end else begin
      busy_q <= busy;
      pend   <= pend_nx;
      word_v <= word_v_nx;
      nxt    <= nxt_nx;
      word   <= word_nx;
    end
  end

  AST_BURST_NEEDS_REQ: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(word_v) |-> $past(pend)); // R5
  AST_ONE_REQUEST: assert property (@(posedge clk) disable iff (!rst_n)
    !(pend && word_v)); // R8
endmodule

// File: rtl/diag_port_out.sv
module diag_port_out
  import diag_port_pkg::*;
#(
  parameter int DATA_W  = 8,
  parameter int BB_DIV  = 6,
  parameter int CIR_DIV = 384,
  parameter int CIR_LEN = 16,
  localparam int ADDR_W = $clog2(CIR_LEN)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              port_dis,
  input  logic              mode_bb,
  input  logic [DATA_W-1:0] bb_i,
  input  logic [DATA_W-1:0] bb_q,
  output logic              bb_take,
  input  logic              cir_busy,
  output logic [ADDR_W-1:0] cir_addr,
  input  logic [DATA_W-1:0] cir_rd_data,
  input  logic              frame_mark,
  output logic              od_en,
  output logic              od_clk,
  output logic [DATA_W-1:0] od_data,
  output logic              od_flag
);
  logic              run, tick, oclk, cir_v, trig_q;
  logic [DATA_W-1:0] bb_word, cir_word;
  lane_e             lane;
  port_mode_e        mode;

  assign run  = !port_dis;
  assign mode = port_mode_e'(mode_bb);

  diag_rate_div #(.BB_DIV(BB_DIV), .CIR_DIV(CIR_DIV)) u_div (
    .clk(clk), .rst_n(rst_n), .run(run), .mode(mode), .tick(tick), .oclk(oclk)
  );

  diag_bb_seq #(.DATA_W(DATA_W)) u_bb (
    .clk(clk), .rst_n(rst_n), .enable(run && (mode == PM_BB)), .tick(tick),
    .bb_i(bb_i), .bb_q(bb_q), .word(bb_word), .lane(lane), .take(bb_take)
  );

  diag_cir_burst #(.DATA_W(DATA_W), .CIR_LEN(CIR_LEN), .ADDR_W(ADDR_W)) u_cir (
    .clk(clk), .rst_n(rst_n), .enable(run && (mode == PM_CIR)), .tick(tick),
    .busy(cir_busy), .rd_data(cir_rd_data), .addr(cir_addr),
    .word(cir_word), .word_v(cir_v)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          trig_q <= 1'b0;
    else if (frame_mark) trig_q <= !trig_q;
  end

  always_comb begin
    od_en   = run;
    od_clk  = 1'b0;
    od_data = '0;
    od_flag = 1'b0;
    if (run) begin
      if (mode == PM_BB) begin
        od_clk  = oclk;
        od_data = bb_word;
        od_flag = (lane == LANE_I);
      end else begin
        od_clk  = oclk && cir_v;
        od_data = cir_word;
        od_flag = trig_q;
      end
    end
  end

  AST_OFF_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    port_dis |-> (!od_en && !od_clk && (od_data == '0) && !od_flag)); // R1
  AST_TRIG_TOGGLES: assert property (@(posedge clk) disable iff (!rst_n)
    (frame_mark && run && !mode_bb && $past(run)) |=> (od_flag != $past(od_flag) || !run || mode_bb)); // R9
endmodule

// File: tb/tb_diag_port_out.sv
module tb_diag_port_out;
  localparam int DW = 8;
  localparam int BBD = 6;
  localparam int CRD = 8;
  localparam int CLEN = 4;
  localparam int AW = $clog2(CLEN);

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic port_dis = 1'b1, mode_bb = 1'b1, cir_busy = 1'b0, frame_mark = 1'b0;
  logic [DW-1:0] bb_i = '0, bb_q = '0;
  logic bb_take, od_en, od_clk, od_flag;
  logic [AW-1:0] cir_addr;
  logic [DW-1:0] cir_rd_data, od_data;

  int checks = 0, errors = 0, cyc = 0, rises = 0, takes = 0;
  int exp_per = 0, exp_hi = 0, last_rise = -1, hi_cnt = 0, lo_cnt = 0;
  logic [9:0] exp_q[$];
  logic prev_clk = 1'b0, prev_en = 1'b0;
  logic [DW-1:0] prev_data = '0;

  always #2 clk = !clk;

  assign cir_rd_data = 8'hA0 + 8'(cir_addr) * 8'd5;

  diag_port_out #(.DATA_W(DW), .BB_DIV(BBD), .CIR_DIV(CRD), .CIR_LEN(CLEN)) dut (
    .clk(clk), .rst_n(rst_n), .port_dis(port_dis), .mode_bb(mode_bb),
    .bb_i(bb_i), .bb_q(bb_q), .bb_take(bb_take), .cir_busy(cir_busy),
    .cir_addr(cir_addr), .cir_rd_data(cir_rd_data), .frame_mark(frame_mark),
    .od_en(od_en), .od_clk(od_clk), .od_data(od_data), .od_flag(od_flag)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic push_word(input bit fchk, input bit f, input logic [DW-1:0] d);
    exp_q.push_back({fchk, f, d});
  endtask

  // monitor / scoreboard
  always @(negedge clk) begin
    logic [9:0] e;
    bit rise;
    cyc++;
    rise = od_clk && !prev_clk;
    if (bb_take) takes++;
    if (rise) begin
      rises++;
      if (exp_q.size() == 0) chk(1'b0, "R5 R6 unexpected word", od_data, -1);
      else begin
        e = exp_q.pop_front();
        chk(od_data == e[7:0], e[9] ? "R2 word" : "R5 word", od_data, e[7:0]);
        if (e[9]) chk(od_flag == e[8], "R3 lane flag", od_flag, e[8]);
      end
      if (last_rise >= 0 && exp_per > 0)
        chk(cyc - last_rise == exp_per, mode_bb ? "R4 period" : "R6 period", cyc - last_rise, exp_per);
      last_rise = cyc;
    end
    if (!od_clk && prev_clk && od_en && exp_hi > 0)
      chk(hi_cnt == exp_hi, mode_bb ? "R4 high time" : "R6 high time", hi_cnt, exp_hi);
    if (od_clk) begin hi_cnt = (rise ? 1 : hi_cnt + 1); lo_cnt = 0; end
    else begin
      lo_cnt++;
      if (lo_cnt > exp_per) last_rise = -1;
    end
    if (od_en && prev_en && od_data != prev_data)
      chk(rise, "R7 data change off rising edge", od_data, prev_data);
    prev_clk = od_clk;
    prev_en = od_en;
    prev_data = od_data;
  end

  initial begin
    #(4 * 100000);
    chk(1'b0, "watchdog", cyc, 0);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    int r0;
    repeat (3) @(negedge clk);
    chk(!od_clk && od_data == 0 && !od_flag && !bb_take, "R10 reset state", od_data, 0);
    rst_n = 1'b1;
    // R1: disabled, busy fall ignored
    mode_bb = 1'b0;
    cir_busy = 1'b1;
    repeat (3) @(negedge clk);
    cir_busy = 1'b0;
    r0 = rises;
    repeat (20) @(negedge clk);
    chk(!od_en && od_data == 0 && !od_flag && rises == r0, "R1 port off", rises - r0, 0);
    port_dis = 1'b0;
    repeat (3 * CRD) @(negedge clk);
    chk(rises == r0, "R1 request while off dropped", rises - r0, 0);
    port_dis = 1'b1;
    @(negedge clk);

    // baseband: R2 R3 R4
    mode_bb = 1'b1;
    exp_per = BBD; exp_hi = BBD / 2;
    bb_i = 8'h03; bb_q = 8'hF0;
    push_word(1, 1, bb_i); push_word(1, 0, bb_q);
    takes = 0;
    @(negedge clk);
    port_dis = 1'b0;
    for (int k = 1; k <= 6; k++) begin
      do @(negedge clk); while (!bb_take);
      if (k < 6) begin
        bb_i = 8'(16 * k + 3);
        bb_q = 8'(8'hF0 - k);
        push_word(1, 1, bb_i); push_word(1, 0, bb_q);
      end
    end
    wait (exp_q.size() == 0);
    repeat (3) @(negedge clk);
    port_dis = 1'b1;
    @(negedge clk);
    chk(takes == 6, "R2 take count", takes, 6);
    chk(!od_en && !od_clk, "R1 off after baseband", od_clk, 0);

    // impulse response: R5 R6
    mode_bb = 1'b0;
    exp_per = CRD; exp_hi = CRD / 2;
    @(negedge clk);
    port_dis = 1'b0;
    r0 = rises;
    repeat (30) @(negedge clk);
    chk(rises == r0, "R6 no clock outside burst", rises - r0, 0);
    cir_busy = 1'b1;
    repeat (5) @(negedge clk);
    for (int a = 0; a < CLEN; a++) push_word(0, 0, 8'hA0 + 8'(a * 5));
    cir_busy = 1'b0;
    wait (exp_q.size() == 0);
    repeat (40) @(negedge clk);
    chk(rises - r0 == CLEN, "R6 burst length", rises - r0, CLEN);

    // R8: request during burst dropped
    r0 = rises;
    cir_busy = 1'b1;
    repeat (2) @(negedge clk);
    for (int a = 0; a < CLEN; a++) push_word(0, 0, 8'hA0 + 8'(a * 5));
    cir_busy = 1'b0;
    wait (exp_q.size() == CLEN - 1);
    cir_busy = 1'b1;
    @(negedge clk);
    cir_busy = 1'b0;
    wait (exp_q.size() == 0);
    repeat (6 * CRD) @(negedge clk);
    chk(rises - r0 == CLEN, "R8 second request dropped", rises - r0, CLEN);

    // R9: trigger flag toggles
    for (int n = 0; n < 2; n++) begin
      logic f0;
      f0 = od_flag;
      frame_mark = 1'b1;
      @(negedge clk);
      frame_mark = 1'b0;
      chk(od_flag == !f0, "R9 trigger toggle", od_flag, !f0);
      repeat (3) @(negedge clk);
      chk(od_flag == !f0, "R9 trigger holds", od_flag, !f0);
    end

    port_dis = 1'b1;
    @(negedge clk);
    chk(!od_en && od_data == 0 && !od_flag, "R1 final off", od_data, 0);
    chk(exp_q.size() == 0, "R5 scoreboard drained", exp_q.size(), 0);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule